// File: doc/BRIEF.md
# Temperature Limit Alert Controller

This block watches a stream of signed temperature results and drives a single alert pin from them. Each time a conversion completes, the new result is compared against a programmable upper and lower limit. A consecutive-fault counter has to reach a programmed depth before any change of the alert takes effect, so that isolated noisy samples are filtered out in both directions.

Two behaviours are available. In comparator mode the pin follows a hysteresis loop: it switches on at the upper limit and off below the lower limit. In interrupt mode each qualified crossing latches an event that holds the pin active until any register read. After each read the block starts watching the opposite limit, so upper and lower events alternate. A shutdown input returns everything to the idle state. The active level of the pin is selectable.

The controller is a five-state machine:
- `ST_IDLE_HI`: inactive, watching the upper limit.
- `ST_CMP_ON`: comparator active, watching the lower limit.
- `ST_INT_HI`: interrupt pending from an upper event.
- `ST_IDLE_LO`: inactive, watching the lower limit.
- `ST_INT_LO`: interrupt pending from a lower event.

The transitions are:
- `ST_IDLE_HI`→`ST_CMP_ON` on a qualified upper fault with mode 0.
- `ST_IDLE_HI`→`ST_INT_HI` on a qualified upper fault with mode 1.
- `ST_CMP_ON`→`ST_IDLE_HI` on a qualified lower fault.
- `ST_INT_HI`→`ST_IDLE_LO` on a read.
- `ST_IDLE_LO`→`ST_INT_LO` on a qualified lower fault.
- `ST_INT_LO`→`ST_IDLE_HI` on a read.
- Any state→`ST_IDLE_HI` while shutdown is high.

Top module: `temp_alert_ctrl`

## Requirements
- R1: After reset the block is in `ST_IDLE_HI`, the alert is inactive and the fault count is zero.
- R2: In `ST_IDLE_HI` with mode 0, a conversion with temperature greater than or equal to the upper limit counts as a fault. When the count reaches the programmed depth, the alert is active from the clock edge that sampled that conversion.
- R3: In comparator mode the active alert stays on for results at or above the lower limit. It turns off only after the programmed depth of consecutive results strictly below the lower limit.
- R4: The 2-bit depth field selects 1, 2, 4 or 6 consecutive faults for codes 00, 01, 10 and 11.
- R5: A conversion that misses the watched condition zeroes the fault count. Cycles without a conversion strobe change neither the count nor the state.
- R6: With mode 1, the programmed depth of consecutive results at or above the upper limit latches the alert. The alert then holds regardless of temperature until a read strobe clears it. While an event is pending, the fault count stays at zero.
- R7: After a read clears an upper event, the block watches the lower limit and latches again after the programmed depth of results strictly below it. After the next read it watches the upper limit again.
- R8: A read strobe while no event is pending has no effect on the alert or on which limit is watched.
- R9: While shutdown is high, the alert is inactive, the state returns to `ST_IDLE_HI` and the fault count is zero. Conversions are ignored.
- R10: The polarity input sets the pin level: with 0 the active level is low, and with 1 the active level is high.
- R11: Temperature and limits are 12-bit two's-complement values compared as signed numbers.
- R12: The mode input is consulted when an upper fault qualifies in `ST_IDLE_HI`: 0 selects comparator, 1 selects interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_done | input | 1 | One-cycle strobe: new temperature result valid |
| temp_in | input | TEMP_W | Signed temperature result |
| lim_hi | input | TEMP_W | Signed upper limit |
| lim_lo | input | TEMP_W | Signed lower limit |
| irq_mode | input | 1 | 0 comparator, 1 interrupt |
| pol_high | input | 1 | 0 active-low pin, 1 active-high pin |
| fq_sel | input | 2 | Fault depth code (00:1, 01:2, 10:4, 11:6) |
| reg_rd | input | 1 | One-cycle strobe: a register was read |
| shutdown | input | 1 | Shutdown level |
| alert_pin | output | 1 | Alert pin level |

## Verification
The bench builds the block with its default width of 12 bits. At this width, limits such as -5 and -20 sit near the top of the unsigned code range, so results like +100 separate a signed comparison from an unsigned one. The depth field spans its full range, which brings the six-deep queue and a mid-queue shutdown within reach. With one behavioural model compared every cycle, mode alternation, idle reads and polarity changes are all checked against the same expectations.

// File: rtl/temp_alert_pkg.sv
package temp_alert_pkg;

    typedef enum logic [2:0] {
        ST_IDLE_HI = 3'd0,
        ST_CMP_ON  = 3'd1,
        ST_INT_HI  = 3'd2,
        ST_IDLE_LO = 3'd3,
        ST_INT_LO  = 3'd4
    } alert_st_e;

    localparam int DEPTH_W = 3;

    function automatic logic [DEPTH_W-1:0] fq_depth(input logic [1:0] code);
        logic [DEPTH_W-1:0] d;
        case (code)
            2'b00:   d = 3'd1;
            2'b01:   d = 3'd2;
            2'b10:   d = 3'd4;
            default: d = 3'd6;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/fault_counter.sv
module fault_counter #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sample,
    input  logic             cond,
    input  logic [CNT_W-1:0] need,
    output logic             hit
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_inc;

    always_comb begin
        cnt_inc = {1'b0, cnt_q} + 1'b1;
        hit     = sample && cond && !clear && (cnt_inc >= {1'b0, need});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (sample) begin
            if (!cond || hit) cnt_q <= '0;
            else              cnt_q <= cnt_inc[CNT_W-1:0];
        end
    end

    p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));

    p_miss_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !cond) |=> (cnt_q == '0));

    p_idle_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample && !clear) |=> $stable(cnt_q));

endmodule

// File: rtl/alert_fsm.sv
module alert_fsm
    import temp_alert_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic irq_mode,
    input  logic reg_rd,
    input  logic shutdown,
    output logic watch_low,
    output logic hold_cnt,
    output logic alert_act
);

    alert_st_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (shutdown) begin
            state_d = ST_IDLE_HI;
        end else begin
            unique case (state_q)
                ST_IDLE_HI: if (hit) state_d = irq_mode ? ST_INT_HI : ST_CMP_ON;
                ST_CMP_ON:  if (hit) state_d = ST_IDLE_HI;
                ST_INT_HI:  if (reg_rd) state_d = ST_IDLE_LO;
                ST_IDLE_LO: if (hit) state_d = ST_INT_LO;
                ST_INT_LO:  if (reg_rd) state_d = ST_IDLE_HI;
                default:    state_d = ST_IDLE_HI;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE_HI;
        else        state_q <= state_d;
    end

    always_comb begin
        watch_low = 1'b0;
        hold_cnt  = 1'b0;
        alert_act = 1'b0;
        unique case (state_q)
            ST_IDLE_HI: ;
            ST_CMP_ON:  begin watch_low = 1'b1; alert_act = 1'b1; end
            ST_INT_HI:  begin hold_cnt = 1'b1;  alert_act = 1'b1; end
            ST_IDLE_LO: watch_low = 1'b1;
            ST_INT_LO:  begin hold_cnt = 1'b1;  alert_act = 1'b1; end
            default:    ;
        endcase
    end

    p_sd_home_r9: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> (state_q == ST_IDLE_HI));

    p_int_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_INT_HI || state_q == ST_INT_LO) && !reg_rd && !shutdown)
        |=> $stable(state_q));

    p_lo_via_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE_LO && $past(state_q) != ST_IDLE_LO)
        |-> ($past(reg_rd) && $past(state_q) == ST_INT_HI));

    p_rise_needs_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alert_act) |-> $past(hit));

endmodule

// File: rtl/temp_alert_ctrl.sv
module temp_alert_ctrl
    import temp_alert_pkg::*;
#(
    parameter int TEMP_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [TEMP_W-1:0] temp_in,
    input  logic [TEMP_W-1:0] lim_hi,
    input  logic [TEMP_W-1:0] lim_lo,
    input  logic              irq_mode,
    input  logic              pol_high,
    input  logic [1:0]        fq_sel,
    input  logic              reg_rd,
    input  logic              shutdown,
    output logic              alert_pin
);

    localparam int CNT_W = DEPTH_W;

    logic             at_or_above_hi;
    logic             below_lo;
    logic             cond;
    logic             hit;
    logic             watch_low;
    logic             hold_cnt;
    logic             alert_act;
    logic [CNT_W-1:0] need;

    always_comb begin
        at_or_above_hi = $signed(temp_in) >= $signed(lim_hi);
        below_lo       = $signed(temp_in) <  $signed(lim_lo);
        cond           = watch_low ? below_lo : at_or_above_hi;
        need           = fq_depth(fq_sel);
    end

    fault_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (shutdown || hold_cnt),
        .sample (conv_done),
        .cond   (cond),
        .need   (need),
        .hit    (hit)
    );

    alert_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .irq_mode  (irq_mode),
        .reg_rd    (reg_rd),
        .shutdown  (shutdown),
        .watch_low (watch_low),
        .hold_cnt  (hold_cnt),
        .alert_act (alert_act)
    );

    always_comb alert_pin = pol_high ? alert_act : !alert_act;

    p_pin_idle_after_sd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> (alert_pin == !pol_high));

endmodule

// File: tb/temp_alert_ctrl_tb_top.sv
module temp_alert_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        conv_done;
    logic [11:0] temp_in, lim_hi, lim_lo;
    logic        irq_mode, pol_high, reg_rd, shutdown;
    logic [1:0]  fq_sel;
    logic        alert_pin;

    int    vectors = 0;
    int    miscompares = 0;
    string cur_req = "R1";

    bit m_on, m_lat, m_dir, m_cond;
    int m_cnt;

    always #4 clk = ~clk;

    temp_alert_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .temp_in(temp_in),
        .lim_hi(lim_hi), .lim_lo(lim_lo), .irq_mode(irq_mode), .pol_high(pol_high),
        .fq_sel(fq_sel), .reg_rd(reg_rd), .shutdown(shutdown), .alert_pin(alert_pin)
    );

    function automatic int depth_of(input logic [1:0] c);
        case (c)
            2'b00:   return 1;
            2'b01:   return 2;
            2'b10:   return 4;
            default: return 6;
        endcase
    endfunction

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n || shutdown) begin
            m_on = 0; m_lat = 0; m_dir = 0; m_cnt = 0;
        end else if (m_lat) begin
            if (reg_rd) begin m_lat = 0; m_on = 0; m_dir = !m_dir; end
            m_cnt = 0;
        end else if (conv_done) begin
            m_cond = m_dir ? ($signed(temp_in) < $signed(lim_lo))
                           : ($signed(temp_in) >= $signed(lim_hi));
            if (m_cond) begin
                m_cnt++;
                if (m_cnt >= depth_of(fq_sel)) begin
                    m_cnt = 0;
                    if (!m_dir) begin
                        if (irq_mode) begin m_on = 1; m_lat = 1; end
                        else begin m_on = 1; m_dir = 1; end
                    end else if (m_on) begin
                        m_on = 0; m_dir = 0;
                    end else begin
                        m_on = 1; m_lat = 1;
                    end
                end
            end else begin
                m_cnt = 0;
            end
        end
    end

    always @(negedge clk) begin
        logic exp_pin;
        #1;
        exp_pin = pol_high ? m_on : !m_on;
        vectors++;
        if (alert_pin !== exp_pin) begin
            miscompares++;
            $display("FAIL %s model compare: actual %b expected %b at %0t",
                     cur_req, alert_pin, exp_pin, $time);
        end
    end

    task automatic expect_on(input bit on, input string tag);
        logic exp_pin;
        #2;
        exp_pin = pol_high ? on : !on;
        vectors++;
        if (alert_pin !== exp_pin) begin
            miscompares++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, alert_pin, exp_pin, $time);
        end
    endtask

    task automatic conv(input int t);
        @(negedge clk); temp_in = 12'(t); conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0;
    endtask

    task automatic conv_n(input int t, input int n);
        for (int i = 0; i < n; i++) conv(t);
    endtask

    task automatic rd_pulse();
        @(negedge clk); reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic sd_pulse();
        @(negedge clk); shutdown = 1'b1;
        @(negedge clk); shutdown = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst_n = 0; conv_done = 0; temp_in = '0; lim_hi = 12'd50; lim_lo = 12'd20;
        irq_mode = 0; pol_high = 0; fq_sel = 2'b00; reg_rd = 0; shutdown = 0;
        idle(3);
        rst_n = 1;
        idle(1);
        expect_on(0, "R1 reset inactive");

        cur_req = "R2";
        conv(49); expect_on(0, "R2 below upper");
        conv(50); expect_on(1, "R2 equal to upper asserts");

        cur_req = "R3";
        conv(30); expect_on(1, "R3 inside hysteresis");
        conv(20); expect_on(1, "R3 equal to lower holds");
        conv(19); expect_on(0, "R3 below lower clears");

        cur_req = "R5";
        fq_sel = 2'b10;
        conv_n(60, 3); expect_on(0, "R4 three of four");
        conv(40); conv_n(60, 3); expect_on(0, "R5 miss restarts count");
        idle(5); expect_on(0, "R5 no strobe no change");
        conv(60); expect_on(1, "R4 fourth fault asserts");
        conv_n(10, 3); expect_on(1, "R4 three lows keep alert");
        conv(10); expect_on(0, "R4 fourth low clears");

        cur_req = "R4";
        fq_sel = 2'b11;
        conv_n(60, 5); expect_on(0, "R4 five of six");
        conv(60); expect_on(1, "R4 sixth asserts");

        cur_req = "R9";
        sd_pulse(); expect_on(0, "R9 shutdown clears alert");
        conv_n(60, 3); sd_pulse();
        conv_n(60, 5); expect_on(0, "R9 counter was cleared");
        conv(60); expect_on(1, "R9 full depth after shutdown");
        @(negedge clk); shutdown = 1; temp_in = 12'd60; conv_done = 1;
        @(negedge clk); conv_done = 0;
        expect_on(0, "R9 conversion ignored in shutdown");
        @(negedge clk); shutdown = 0;

        cur_req = "R6";
        irq_mode = 1; fq_sel = 2'b01;
        conv(60); expect_on(0, "R6 one of two");
        conv(60); expect_on(1, "R12 interrupt latched");
        conv_n(10, 3); expect_on(1, "R6 holds with cold results");
        idle(4); expect_on(1, "R6 holds without read");
        rd_pulse(); expect_on(0, "R6 read clears");

        cur_req = "R7";
        conv_n(60, 3); expect_on(0, "R7 upper ignored after read");
        conv(10); expect_on(0, "R7 one low");
        conv(10); expect_on(1, "R7 low event latched");
        rd_pulse(); expect_on(0, "R7 read clears low event");
        conv_n(10, 2); expect_on(0, "R7 low ignored after second read");
        conv_n(60, 2); expect_on(1, "R7 back to upper");
        rd_pulse(); expect_on(0, "R7 read clears");

        cur_req = "R8";
        rd_pulse(); expect_on(0, "R8 idle read no effect");
        conv_n(60, 2); expect_on(0, "R8 still watching lower");
        conv_n(10, 2); expect_on(1, "R8 low event after idle read");
        rd_pulse();

        cur_req = "R10";
        pol_high = 1;
        idle(1); expect_on(0, "R10 active-high idle low");
        if (alert_pin !== 1'b0) begin
            miscompares++;
            $display("FAIL R10 pin level: actual %b expected 0", alert_pin);
        end
        vectors++;
        conv_n(60, 2); expect_on(1, "R10 active-high asserted");
        if (alert_pin !== 1'b1) begin
            miscompares++;
            $display("FAIL R10 pin level: actual %b expected 1", alert_pin);
        end
        vectors++;
        rd_pulse();

        cur_req = "R11";
        sd_pulse();
        irq_mode = 0; fq_sel = 2'b00; pol_high = 0;
        lim_hi = 12'hFFB; lim_lo = 12'hFEC;
        conv(-6); expect_on(0, "R11 -6 below -5");
        conv(-5); expect_on(1, "R11 -5 meets upper");
        conv(-20); expect_on(1, "R11 -20 not below -20");
        conv(-21); expect_on(0, "R11 -21 clears");
        conv(100); expect_on(1, "R11 +100 above -5 signed");

        idle(3);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule